// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block sits beside a small processor core and decides when the core must abandon its instruction stream to service an interrupt, and at which fixed entry address. Each of up to eighteen sources presents a pending flag, an enable and a priority bit. In prioritized mode every source is either high or low level. Each level has its own global enable and its own entry address. A high-level request may interrupt a low-level service routine, but not the reverse. In single-level mode every request enters at the high address under one global enable, and the higher-numbered peripheral sources also need a peripheral enable.

The core presents an instruction-boundary strobe. When a request is pending on that strobe, the controller answers on the next clock. It pulses a take strobe, which tells the core to push its return address. It presents the entry address, pulses a clear for the global enable of the level taken, and copies the core's status, bank-select and working registers into shadow registers. A return strobe ends the most recently entered level and pulses a set for that level's global enable. With the fast qualifier, the return also pulses a restore strobe so that the core reloads its context from the shadows.

The global enable bits are held by the core. The controller reads them as inputs and asks for changes through the clear and set strobes.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When `prio_en_i` is 1, a source whose `ipri_i` bit is 1 is high level and one whose bit is 0 is low level. Source 0 is always high level, whatever its priority bit.
- R2: A high-level response presents entry address 0x000008 on `vec_o`, and a low-level response presents 0x000018.
- R3: `irq_req_o` is combinational. It is 1 exactly when some source has both its flag and its enable at 1, and the global enable for that source's level is 1, and that level is not blocked by service state.
- R4: In prioritized mode, `glb_hi_i` gates only high-level sources and `glb_lo_i` gates only low-level sources.
- R5: A response is taken only on a clock edge where `boundary_i` and `irq_req_o` are both 1. One cycle later `take_o` pulses for one cycle, together with exactly one of `clr_hi_o` (high level) or `clr_lo_o` (low level).
- R6: A high-level request can be taken while low-level service is active, which sets `svc_hi_o` and leaves `svc_lo_o` set. While `svc_hi_o` is 1, no request is raised. When high and low requests are pending together, the high one is taken.
- R7: A `ret_i` strobe ends the innermost active level: high service first, then low service. One cycle later it pulses `set_hi_o` or `set_lo_o` for that level and clears the matching service bit. With no service active, a return pulses `set_hi_o`.
- R8: When `prio_en_i` is 0, every response enters at 0x000008 under `glb_hi_i`, clears with `clr_hi_o` and sets `svc_hi_o`. Sources 0 to 4 ignore `glb_lo_i`; sources 5 to 17 also require `glb_lo_i` = 1.
- R9: Every response overwrites the three shadow outputs with the `status_i`, `bsr_i` and `wreg_i` values of the taking edge. A return with `ret_fast_i` = 1 pulses `restore_o` one cycle later, and the shadows are unchanged by the return.
- R10: When `ret_i` and `boundary_i` arrive in the same cycle, only the return is processed, and no response is taken on that edge.
- R11: After reset, every strobe, the service bits, `vec_o` and the shadows are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prio_en_i | input | 1 | 1 = prioritized mode, 0 = single-level mode |
| flag_i | input | 18 | Per-source pending flags |
| ien_i | input | 18 | Per-source enables |
| ipri_i | input | 18 | Per-source priority (1 = high) |
| glb_hi_i | input | 1 | High-level global enable (the only global enable in single-level mode) |
| glb_lo_i | input | 1 | Low-level global enable (peripheral enable in single-level mode) |
| boundary_i | input | 1 | Instruction-boundary strobe |
| ret_i | input | 1 | Return-from-interrupt strobe |
| ret_fast_i | input | 1 | Return restores context from the shadows |
| status_i | input | 8 | Core status register value |
| bsr_i | input | 8 | Core bank-select register value |
| wreg_i | input | 8 | Core working register value |
| irq_req_o | output | 1 | Request pending |
| take_o | output | 1 | Response taken; core pushes its return address |
| vec_o | output | 21 | Entry address of the latest response |
| clr_hi_o | output | 1 | Clear the high-level global enable |
| clr_lo_o | output | 1 | Clear the low-level global enable |
| set_hi_o | output | 1 | Set the high-level global enable |
| set_lo_o | output | 1 | Set the low-level global enable |
| svc_hi_o | output | 1 | High-level service active |
| svc_lo_o | output | 1 | Low-level service active |
| restore_o | output | 1 | Core reloads its context from the shadows |
| shd_status_o | output | 8 | Shadow of status |
| shd_bsr_o | output | 8 | Shadow of bank select |
| shd_wreg_o | output | 8 | Shadow of working register |

## Verification
`irq_req_o` is due in the same cycle as the inputs that cause it. The bench therefore samples it 1 ns after driving the inputs, well before the next rising edge. Every other result (the take, set and clear strobes, the entry address, the service bits, the shadows and the restore strobe) comes from a single register stage. These are due one rising edge after the boundary or return strobe, and the bench compares them at the following falling edge against its model of the service state. Directed sequences cover nesting, single-level gating, the return-and-boundary collision and shadow overwrite, and seeded random cycles then exercise everything else.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NSRC  = 18,
  parameter int NCORE = 5,
  parameter int AW    = 21,
  parameter int DW    = 8,
  parameter logic [AW-1:0] HI_VEC = AW'(8),
  parameter logic [AW-1:0] LO_VEC = AW'(24)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prio_en_i,
  input  logic [NSRC-1:0] flag_i,
  input  logic [NSRC-1:0] ien_i,
  input  logic [NSRC-1:0] ipri_i,
  input  logic            glb_hi_i,
  input  logic            glb_lo_i,
  input  logic            boundary_i,
  input  logic            ret_i,
  input  logic            ret_fast_i,
  input  logic [DW-1:0]   status_i,
  input  logic [DW-1:0]   bsr_i,
  input  logic [DW-1:0]   wreg_i,
  output logic            irq_req_o,
  output logic            take_o,
  output logic [AW-1:0]   vec_o,
  output logic            clr_hi_o,
  output logic            clr_lo_o,
  output logic            set_hi_o,
  output logic            set_lo_o,
  output logic            svc_hi_o,
  output logic            svc_lo_o,
  output logic            restore_o,
  output logic [DW-1:0]   shd_status_o,
  output logic [DW-1:0]   shd_bsr_o,
  output logic [DW-1:0]   shd_wreg_o
);

  localparam logic [NSRC-1:0] CORE_MASK = NSRC'((64'd1 << NCORE) - 64'd1);
  localparam logic [NSRC-1:0] FORCE_HI  = NSRC'(1);

  logic [NSRC-1:0] act, is_hi, cmp_gate;
  logic p_hi, p_lo, c_req, want_hi, go;

  assign act      = flag_i & ien_i;
  assign is_hi    = ipri_i | FORCE_HI;
  assign cmp_gate = CORE_MASK | ({NSRC{glb_lo_i}} & ~CORE_MASK);

  assign p_hi  = prio_en_i & glb_hi_i & ~svc_hi_o & (|(act & is_hi));
  assign p_lo  = prio_en_i & glb_lo_i & ~svc_hi_o & ~svc_lo_o & (|(act & ~is_hi));
  assign c_req = ~prio_en_i & glb_hi_i & ~svc_hi_o & (|(act & cmp_gate));

  assign want_hi   = p_hi | c_req;
  assign irq_req_o = want_hi | p_lo;
  assign go        = boundary_i & ~ret_i & irq_req_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o       <= 1'b0;
      vec_o        <= '0;
      clr_hi_o     <= 1'b0;
      clr_lo_o     <= 1'b0;
      set_hi_o     <= 1'b0;
      set_lo_o     <= 1'b0;
      svc_hi_o     <= 1'b0;
      svc_lo_o     <= 1'b0;
      restore_o    <= 1'b0;
      shd_status_o <= '0;
      shd_bsr_o    <= '0;
      shd_wreg_o   <= '0;
    end else begin
      take_o    <= 1'b0;
      clr_hi_o  <= 1'b0;
      clr_lo_o  <= 1'b0;
      set_hi_o  <= 1'b0;
      set_lo_o  <= 1'b0;
      restore_o <= 1'b0;
      if (ret_i) begin
        restore_o <= ret_fast_i;
        if (svc_hi_o) begin
          set_hi_o <= 1'b1;
          svc_hi_o <= 1'b0;
        end else if (svc_lo_o) begin
          set_lo_o <= 1'b1;
          svc_lo_o <= 1'b0;
        end else begin
          set_hi_o <= 1'b1;
        end
      end else if (go) begin
        take_o       <= 1'b1;
        shd_status_o <= status_i;
        shd_bsr_o    <= bsr_i;
        shd_wreg_o   <= wreg_i;
        if (want_hi) begin
          vec_o    <= HI_VEC;
          clr_hi_o <= 1'b1;
          svc_hi_o <= 1'b1;
        end else begin
          vec_o    <= LO_VEC;
          clr_lo_o <= 1'b1;
          svc_lo_o <= 1'b1;
        end
      end
    end
  end

  a_r5_take_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ($past(boundary_i) && !$past(ret_i)));

  a_r5_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ($countones({clr_hi_o, clr_lo_o}) == 1));

  a_r2_lo_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && clr_lo_o) |-> (vec_o == LO_VEC));

  a_r6_no_lo_under_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && clr_lo_o) |-> !$past(svc_hi_o));

  a_r7_set_after_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hi_o || set_lo_o) |-> $past(ret_i));

  a_r7_one_set: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_hi_o, set_lo_o, take_o}));

  a_r8_single_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !$past(prio_en_i)) |-> (vec_o == HI_VEC && clr_hi_o));

  a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> ($stable(shd_status_o) && $stable(shd_bsr_o) && $stable(shd_wreg_o)));

  a_r9_restore_after_fast: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |-> ($past(ret_i) && $past(ret_fast_i)));

endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
  localparam int NSRC = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prio_en_i = 1'b0;
  logic [NSRC-1:0] flag_i = '0, ien_i = '0, ipri_i = '0;
  logic glb_hi_i = 1'b0, glb_lo_i = 1'b0;
  logic boundary_i = 1'b0, ret_i = 1'b0, ret_fast_i = 1'b0;
  logic [7:0] status_i = '0, bsr_i = '0, wreg_i = '0;
  logic irq_req_o, take_o, clr_hi_o, clr_lo_o, set_hi_o, set_lo_o;
  logic svc_hi_o, svc_lo_o, restore_o;
  logic [20:0] vec_o;
  logic [7:0] shd_status_o, shd_bsr_o, shd_wreg_o;

  int n_chk = 0;
  int n_fail = 0;

  // model state
  bit m_hi, m_lo, m_take, m_chi, m_clo, m_shi, m_slo, m_rst;
  logic [20:0] m_vec;
  logic [7:0] m_st, m_bs, m_wr;

  always #2 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .prio_en_i(prio_en_i), .flag_i(flag_i),
    .ien_i(ien_i), .ipri_i(ipri_i), .glb_hi_i(glb_hi_i), .glb_lo_i(glb_lo_i),
    .boundary_i(boundary_i), .ret_i(ret_i), .ret_fast_i(ret_fast_i),
    .status_i(status_i), .bsr_i(bsr_i), .wreg_i(wreg_i),
    .irq_req_o(irq_req_o), .take_o(take_o), .vec_o(vec_o),
    .clr_hi_o(clr_hi_o), .clr_lo_o(clr_lo_o), .set_hi_o(set_hi_o),
    .set_lo_o(set_lo_o), .svc_hi_o(svc_hi_o), .svc_lo_o(svc_lo_o),
    .restore_o(restore_o), .shd_status_o(shd_status_o),
    .shd_bsr_o(shd_bsr_o), .shd_wreg_o(shd_wreg_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // high-level candidate under current inputs and model state
  function automatic bit hi_cand();
    bit r = 0;
    for (int i = 0; i < NSRC; i++) begin
      bit live = flag_i[i] && ien_i[i];
      if (prio_en_i) begin
        if (live && (ipri_i[i] || i == 0)) r = 1;
      end else begin
        if (live && (i < 5 || glb_lo_i)) r = 1;
      end
    end
    return r && glb_hi_i && !m_hi;
  endfunction

  function automatic bit lo_cand();
    bit r = 0;
    for (int i = 1; i < NSRC; i++)
      if (flag_i[i] && ien_i[i] && !ipri_i[i]) r = 1;
    return prio_en_i && r && glb_lo_i && !m_hi && !m_lo;
  endfunction

  task automatic step(string tag);
    bit eh, el;
    #1;
    eh = hi_cand();
    el = lo_cand();
    chk({tag, " R3 req"}, irq_req_o, eh || el);
    m_take = 0; m_chi = 0; m_clo = 0; m_shi = 0; m_slo = 0; m_rst = 0;
    if (ret_i) begin
      m_rst = ret_fast_i;
      if (m_hi) begin m_shi = 1; m_hi = 0; end
      else if (m_lo) begin m_slo = 1; m_lo = 0; end
      else m_shi = 1;
    end else if (boundary_i && (eh || el)) begin
      m_take = 1;
      m_st = status_i; m_bs = bsr_i; m_wr = wreg_i;
      if (eh) begin m_vec = 21'h8; m_chi = 1; m_hi = 1; end
      else begin m_vec = 21'h18; m_clo = 1; m_lo = 1; end
    end
    @(negedge clk);
    chk({tag, " R5 take"}, take_o, m_take);
    chk({tag, " R2 vec"}, vec_o, m_vec);
    chk({tag, " R5 clear"}, {clr_hi_o, clr_lo_o}, {m_chi, m_clo});
    chk({tag, " R7 set"}, {set_hi_o, set_lo_o}, {m_shi, m_slo});
    chk({tag, " R6 svc"}, {svc_hi_o, svc_lo_o}, {m_hi, m_lo});
    chk({tag, " R9 restore"}, restore_o, m_rst);
    chk({tag, " R9 shadow"}, {shd_status_o, shd_bsr_o, shd_wreg_o}, {m_st, m_bs, m_wr});
  endtask

  task automatic idle();
    flag_i = '0; ien_i = '0; ipri_i = '0;
    boundary_i = 0; ret_i = 0; ret_fast_i = 0;
  endtask

  task automatic ctx(logic [7:0] s, logic [7:0] b, logic [7:0] w);
    status_i = s; bsr_i = b; wreg_i = w;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1717));
    m_vec = '0; m_st = '0; m_bs = '0; m_wr = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 strobes", {take_o, clr_hi_o, clr_lo_o, set_hi_o, set_lo_o, restore_o}, 6'b0);
    chk("R11 svc", {svc_hi_o, svc_lo_o}, 2'b0);
    chk("R11 vec/shadow", {vec_o, shd_status_o, shd_bsr_o, shd_wreg_o}, '0);
    rst_n = 1;
    @(negedge clk);

    // R1: source 0 is high although its priority bit is 0
    prio_en_i = 1; glb_hi_i = 1; glb_lo_i = 0;
    flag_i[0] = 1; ien_i[0] = 1; ctx(8'h11, 8'h02, 8'h33);
    step("R1 no-boundary");
    boundary_i = 1; step("R1 src0 high");
    idle(); ret_i = 1; step("R7 return hi");
    idle();

    // R4: low source gated only by glb_lo_i
    glb_hi_i = 1; glb_lo_i = 0;
    flag_i[6] = 1; ien_i[6] = 1; boundary_i = 1;
    step("R4 low blocked");
    glb_lo_i = 1; glb_hi_i = 0; ctx(8'h44, 8'h05, 8'h66);
    step("R4 low taken");
    // R6: high preempts low service
    boundary_i = 1; glb_hi_i = 1; flag_i[9] = 1; ien_i[9] = 1; ipri_i[9] = 1;
    ctx(8'h77, 8'h08, 8'h99);
    step("R6 preempt");
    boundary_i = 1; step("R6 blocked under hi");
    // R10: return beats boundary
    ret_i = 1; boundary_i = 1; step("R10 collision");
    boundary_i = 0; ret_i = 0; ipri_i[9] = 0; flag_i[9] = 0;
    // R9: fast return of low level
    ret_i = 1; ret_fast_i = 1; step("R9 fast ret lo");
    idle(); ret_i = 1; step("R7 empty return");
    idle();

    // R6: simultaneous high and low, high wins
    glb_hi_i = 1; glb_lo_i = 1;
    flag_i[3] = 1; ien_i[3] = 1; ipri_i[3] = 1;
    flag_i[12] = 1; ien_i[12] = 1; boundary_i = 1;
    step("R6 both pending");
    idle(); ret_i = 1; step("R7 ret");
    idle();

    // R8: single-level mode
    prio_en_i = 0; glb_hi_i = 1; glb_lo_i = 0;
    flag_i[7] = 1; ien_i[7] = 1; ipri_i[7] = 0; boundary_i = 1;
    step("R8 periph gated");
    glb_lo_i = 1; ctx(8'hA1, 8'h0B, 8'hC2);
    step("R8 periph taken");
    idle(); ret_i = 1; step("R8 ret");
    idle(); glb_lo_i = 0;
    flag_i[2] = 1; ien_i[2] = 1; boundary_i = 1; ctx(8'hD3, 8'h0E, 8'hF4);
    step("R8 core source");
    idle(); ret_i = 1; ret_fast_i = 1; step("R9 fast ret");
    idle();
    glb_hi_i = 0; flag_i[2] = 1; ien_i[2] = 1; boundary_i = 1;
    step("R8 global off");
    idle();

    // random phase
    for (int k = 0; k < 3000; k++) begin
      prio_en_i = ($urandom_range(0, 7) != 0);
      flag_i = NSRC'($urandom) & NSRC'($urandom) & NSRC'($urandom);
      ien_i = NSRC'($urandom);
      ipri_i = NSRC'($urandom);
      glb_hi_i = ($urandom_range(0, 3) != 0);
      glb_lo_i = ($urandom_range(0, 3) != 0);
      boundary_i = $urandom_range(0, 1);
      ret_i = ($urandom_range(0, 5) == 0);
      ret_fast_i = $urandom_range(0, 1);
      ctx(8'($urandom), 8'($urandom), 8'($urandom));
      step("rand");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule